// File: doc/BRIEF.md
# Parallel Port Floppy Mode Switch

This block lets a parallel port give up its pins to a floppy disk controller. A two-bit mode field picks one of three conditions. In normal operation the port works as usual. In single-drive floppy mode the port pins carry the controller signals for drive 1 only. In dual-drive floppy mode they carry the signals for drives 0 and 1. The mode field is registered, so a new setting takes effect one clock after it is sampled.

While a floppy mode is active, the host-visible registers of the port are masked. The data register returns the last value the host wrote to it. The control and status registers return a fixed image that looks like a port with no cable attached. The DMA acknowledge is ignored, and the DMA request and interrupt pins follow fixed floating or driving rules. When the drive-select register picks a drive that is routed through the port, the controller's own floppy pins are released to high impedance. The port leaves floppy operation only when the mode field returns to normal.

Top module: `ppfd_mode_switch`

## Requirements
- R1: The mode field is sampled on each clock. Value 2'b00 selects normal mode, 2'b01 selects single-drive floppy mode, and 2'b10 selects dual-drive floppy mode. The reserved value 2'b11 behaves as normal. The selected mode takes effect on the outputs one clock after the field is sampled. Floppy mode persists until the field returns to 00 or 11.
- R2: In normal mode, every pin value, pin enable, DMA request, interrupt and register readback is passed through unchanged from the port's own logic.
- R3: In either floppy mode, pin i carries controller bundle bit i for i < 10. The bundle order is: bit0 write data, bit1 density, bit2 head select, bit3 write gate, bit4 direction, bit5 step, bit6 drive select 1, bit7 drive select 0, bit8 motor 0, bit9 motor 1. Those ten pins are enabled, except that in single-drive mode pins 7 and 8 are floated. Pins 10 and above are floated and drive 0.
- R4: In floppy mode, the data readback returns the last value presented with the host write strobe. Writes are captured in any mode. The captured value is 0 after reset.
- R5: In floppy mode, the control readback is 8'h04: strobe bit0 = 0, auto-feed bit1 = 0, init bit2 = 1, select-in bit3 = 0, and all other bits 0.
- R6: In floppy mode, the status readback is 8'h48: nERR bit3 = 1, SLCT bit4 = 0, PE bit5 = 0, nACK bit6 = 1, nBUSY bit7 = 0, and all other bits 0.
- R7: In floppy mode, the DMA acknowledge seen by the port logic is held inactive (1), whatever the pad shows.
- R8: In floppy mode, the DMA request pin drives 0 when ECP mode and DMA enable are both set. Otherwise it floats.
- R9: In floppy mode, the interrupt pin output is 0. Its enable is the inverse of the float configuration bit.
- R10: All ten native floppy pin enables are 0 when the drive-select value names a drive that is routed to the port: drive 1 in single-drive mode, or drive 0 or 1 in dual-drive mode. Otherwise all ten enables are 1.
- R11: Synchronous reset puts the block in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_field | input | 2 | Mode setting from the configuration register |
| ecp_mode | input | 1 | Port is configured for ECP mode |
| dma_en | input | 1 | Port DMA enable |
| irq_float | input | 1 | 1 = interrupt pin floats in floppy mode, 0 = it drives low |
| fdc_drv_sel | input | 2 | Drive number from the drive-select register |
| fdc_sig | input | 10 | Controller output bundle (bit order in R3) |
| fdc_pad_oe | output | 10 | Enables for the native floppy pins |
| pp_norm_out | input | PIN_W | Pin values from the port logic |
| pp_norm_oe | input | PIN_W | Pin enables from the port logic |
| pp_pin_out | output | PIN_W | Pin values to the pads |
| pp_pin_oe | output | PIN_W | Pin enables to the pads |
| pp_drq_in | input | 1 | DMA request from the port logic |
| pp_drq_oe_in | input | 1 | DMA request enable from the port logic |
| pp_drq_out | output | 1 | DMA request pad value |
| pp_drq_oe | output | 1 | DMA request pad enable |
| pp_irq_in | input | 1 | Interrupt from the port logic |
| pp_irq_oe_in | input | 1 | Interrupt enable from the port logic |
| pp_irq_out | output | 1 | Interrupt pad value |
| pp_irq_oe | output | 1 | Interrupt pad enable |
| pad_dack_n | input | 1 | DMA acknowledge from the pad, active low |
| port_dack_n | output | 1 | DMA acknowledge to the port logic, active low |
| host_wr_data | input | 8 | Data written to the port data register |
| host_wr_en | input | 1 | Write strobe for the data register |
| port_data_rd | input | 8 | Normal data readback |
| port_ctrl_rd | input | 8 | Normal control readback |
| port_stat_rd | input | 8 | Normal status readback |
| host_data_rd | output | 8 | Data readback to the host |
| host_ctrl_rd | output | 8 | Control readback to the host |
| host_stat_rd | output | 8 | Status readback to the host |

## Verification
Some rules are checked by assertions on every cycle while floppy mode is active. These are: the fixed control and status images, the inactive DMA acknowledge, the DMA request and interrupt pin rules, the release of the native pins, and the one-clock mode follow. The bench scenarios are needed for the rest. Pass-through in normal mode, the reserved mode code, and recall of the last write (including a write made before entering floppy mode) can only be shown this way. So can the zero data value after reset and the per-pin enable difference between the two floppy modes.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;

    localparam int FDC_W  = 10;
    localparam int REG_W  = 8;
    localparam int BIT_DS0  = 7;
    localparam int BIT_MTR0 = 8;

    localparam logic [REG_W-1:0] CTRL_IMAGE = 8'h04;
    localparam logic [REG_W-1:0] STAT_IMAGE = 8'h48;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_FLP1   = 2'b01,
        PM_FLP2   = 2'b10
    } pmode_e;

    typedef struct packed {
        pmode_e mode;
        logic   active;
        logic   dual;
    } mode_ctl_t;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] stat;
    } regview_t;

    function automatic pmode_e decode_mode(input logic [1:0] f);
        case (f)
            2'b01:   return PM_FLP1;
            2'b10:   return PM_FLP2;
            default: return PM_NORMAL;
        endcase
    endfunction

    function automatic logic drive_routed(input mode_ctl_t m, input logic [1:0] sel);
        if (!m.active) return 1'b0;
        if (m.dual)    return (sel == 2'd0) || (sel == 2'd1);
        return sel == 2'd1;
    endfunction

endpackage

// File: rtl/ppfd_mode_decode.sv
module ppfd_mode_decode
    import ppfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] mode_field,
    output mode_ctl_t ctl
);
    pmode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_NORMAL;
        else     mode_q <= decode_mode(mode_field);
    end

    always_comb begin
        ctl.mode   = mode_q;
        ctl.active = (mode_q != PM_NORMAL);
        ctl.dual   = (mode_q == PM_FLP2);
    end

    AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_field == 2'b01) |=> ctl.active && !ctl.dual); // R1
    AST_RESERVED_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (mode_field == 2'b11) |=> !ctl.active); // R1
    AST_RESET_NORMAL: assert property (@(posedge clk)
        rst |=> !ctl.active); // R11
endmodule

// File: rtl/ppfd_pin_mux.sv
module ppfd_pin_mux
    import ppfd_pkg::*;
#(
    parameter int PIN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_ctl_t        ctl,
    input  logic             ecp_mode,
    input  logic             dma_en,
    input  logic             irq_float,
    input  logic [1:0]       fdc_drv_sel,
    input  logic [FDC_W-1:0] fdc_sig,
    output logic [FDC_W-1:0] fdc_pad_oe,
    input  logic [PIN_W-1:0] pp_norm_out,
    input  logic [PIN_W-1:0] pp_norm_oe,
    output logic [PIN_W-1:0] pp_pin_out,
    output logic [PIN_W-1:0] pp_pin_oe,
    input  logic             pp_drq_in,
    input  logic             pp_drq_oe_in,
    output logic             pp_drq_out,
    output logic             pp_drq_oe,
    input  logic             pp_irq_in,
    input  logic             pp_irq_oe_in,
    output logic             pp_irq_out,
    output logic             pp_irq_oe,
    input  logic             pad_dack_n,
    output logic             port_dack_n
);
    logic routed;

    always_comb routed = drive_routed(ctl, fdc_drv_sel);
    assign fdc_pad_oe = routed ? '0 : '1;

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        logic flp_out, flp_oe;
        if (i < FDC_W) begin : g_fdc
            assign flp_out = fdc_sig[i];
            if (i == BIT_DS0 || i == BIT_MTR0) begin : g_drv0
                assign flp_oe = ctl.dual;
            end else begin : g_common
                assign flp_oe = 1'b1;
            end
        end else begin : g_spare
            assign flp_out = 1'b0;
            assign flp_oe  = 1'b0;
        end
        assign pp_pin_out[i] = ctl.active ? flp_out : pp_norm_out[i];
        assign pp_pin_oe[i]  = ctl.active ? flp_oe  : pp_norm_oe[i];
    end

    always_comb begin
        if (ctl.active) begin
            pp_drq_out  = 1'b0;
            pp_drq_oe   = ecp_mode & dma_en;
            pp_irq_out  = 1'b0;
            pp_irq_oe   = ~irq_float;
            port_dack_n = 1'b1;
        end else begin
            pp_drq_out  = pp_drq_in;
            pp_drq_oe   = pp_drq_oe_in;
            pp_irq_out  = pp_irq_in;
            pp_irq_oe   = pp_irq_oe_in;
            port_dack_n = pad_dack_n;
        end
    end

    AST_DACK_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        ctl.active |-> port_dack_n); // R7
    AST_DRQ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (ctl.active && !(ecp_mode && dma_en)) |-> !pp_drq_oe); // R8
    AST_DRQ_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl.active && pp_drq_oe) |-> !pp_drq_out); // R8
    AST_IRQ_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        ctl.active |-> !pp_irq_out); // R9
    AST_NATIVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ctl.active && fdc_drv_sel == 2'd1) |-> (fdc_pad_oe == '0)); // R10
    AST_NATIVE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!ctl.active || fdc_drv_sel[1]) |-> (fdc_pad_oe == '1)); // R10
    AST_SPARE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        ctl.active |-> (pp_pin_oe[PIN_W-1:FDC_W] == '0)); // R3
endmodule

// File: rtl/ppfd_readback.sv
module ppfd_readback
    import ppfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_ctl_t        ctl,
    input  logic [REG_W-1:0] host_wr_data,
    input  logic             host_wr_en,
    input  regview_t         port_view,
    output regview_t         host_view
);
    logic [REG_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst)             data_q <= '0;
        else if (host_wr_en) data_q <= host_wr_data;
    end

    always_comb begin
        if (ctl.active) begin
            host_view.data = data_q;
            host_view.ctrl = CTRL_IMAGE;
            host_view.stat = STAT_IMAGE;
        end else begin
            host_view = port_view;
        end
    end

    AST_CTRL_IMAGE: assert property (@(posedge clk) disable iff (rst)
        ctl.active |-> (host_view.ctrl[3:0] == 4'b0100)); // R5
    AST_STAT_IMAGE: assert property (@(posedge clk) disable iff (rst)
        ctl.active |-> (host_view.stat[7:3] == 5'b01001)); // R6
    AST_DATA_RECALL: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && ctl.mode != PM_NORMAL && $stable(ctl.mode))
        |=> (!ctl.active || host_view.data == $past(host_wr_data))); // R4
endmodule

// File: rtl/ppfd_mode_switch.sv
module ppfd_mode_switch
    import ppfd_pkg::*;
#(
    parameter int PIN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_field,
    input  logic             ecp_mode,
    input  logic             dma_en,
    input  logic             irq_float,
    input  logic [1:0]       fdc_drv_sel,
    input  logic [9:0]       fdc_sig,
    output logic [9:0]       fdc_pad_oe,
    input  logic [PIN_W-1:0] pp_norm_out,
    input  logic [PIN_W-1:0] pp_norm_oe,
    output logic [PIN_W-1:0] pp_pin_out,
    output logic [PIN_W-1:0] pp_pin_oe,
    input  logic             pp_drq_in,
    input  logic             pp_drq_oe_in,
    output logic             pp_drq_out,
    output logic             pp_drq_oe,
    input  logic             pp_irq_in,
    input  logic             pp_irq_oe_in,
    output logic             pp_irq_out,
    output logic             pp_irq_oe,
    input  logic             pad_dack_n,
    output logic             port_dack_n,
    input  logic [7:0]       host_wr_data,
    input  logic             host_wr_en,
    input  logic [7:0]       port_data_rd,
    input  logic [7:0]       port_ctrl_rd,
    input  logic [7:0]       port_stat_rd,
    output logic [7:0]       host_data_rd,
    output logic [7:0]       host_ctrl_rd,
    output logic [7:0]       host_stat_rd
);
    mode_ctl_t ctl;
    regview_t  port_view, host_view;

    assign port_view.data = port_data_rd;
    assign port_view.ctrl = port_ctrl_rd;
    assign port_view.stat = port_stat_rd;
    assign host_data_rd   = host_view.data;
    assign host_ctrl_rd   = host_view.ctrl;
    assign host_stat_rd   = host_view.stat;

    ppfd_mode_decode u_decode (
        .clk(clk), .rst(rst), .mode_field(mode_field), .ctl(ctl)
    );

    ppfd_pin_mux #(.PIN_W(PIN_W)) u_pins (
        .clk(clk), .rst(rst), .ctl(ctl),
        .ecp_mode(ecp_mode), .dma_en(dma_en), .irq_float(irq_float),
        .fdc_drv_sel(fdc_drv_sel), .fdc_sig(fdc_sig), .fdc_pad_oe(fdc_pad_oe),
        .pp_norm_out(pp_norm_out), .pp_norm_oe(pp_norm_oe),
        .pp_pin_out(pp_pin_out), .pp_pin_oe(pp_pin_oe),
        .pp_drq_in(pp_drq_in), .pp_drq_oe_in(pp_drq_oe_in),
        .pp_drq_out(pp_drq_out), .pp_drq_oe(pp_drq_oe),
        .pp_irq_in(pp_irq_in), .pp_irq_oe_in(pp_irq_oe_in),
        .pp_irq_out(pp_irq_out), .pp_irq_oe(pp_irq_oe),
        .pad_dack_n(pad_dack_n), .port_dack_n(port_dack_n)
    );

    ppfd_readback u_regs (
        .clk(clk), .rst(rst), .ctl(ctl),
        .host_wr_data(host_wr_data), .host_wr_en(host_wr_en),
        .port_view(port_view), .host_view(host_view)
    );
endmodule

// File: tb/tb_ppfd_mode_switch.sv
module tb_ppfd_mode_switch;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_W = 17;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] mode_field = '0, fdc_drv_sel = '0;
    logic ecp_mode = 0, dma_en = 0, irq_float = 0;
    logic [9:0] fdc_sig = '0, fdc_pad_oe;
    logic [PIN_W-1:0] pp_norm_out = '0, pp_norm_oe = '0, pp_pin_out, pp_pin_oe;
    logic pp_drq_in = 0, pp_drq_oe_in = 0, pp_drq_out, pp_drq_oe;
    logic pp_irq_in = 0, pp_irq_oe_in = 0, pp_irq_out, pp_irq_oe;
    logic pad_dack_n = 1, port_dack_n;
    logic [7:0] host_wr_data = '0, port_data_rd = '0, port_ctrl_rd = '0, port_stat_rd = '0;
    logic host_wr_en = 0;
    logic [7:0] host_data_rd, host_ctrl_rd, host_stat_rd;

    int n_checks = 0, n_fail = 0;
    int m_mode = 0;
    logic [7:0] m_data = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppfd_mode_switch #(.PIN_W(PIN_W)) dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PIN_W-1:0] exp_pin_oe(int m);
        logic [PIN_W-1:0] v;
        if (m == 0) return pp_norm_oe;
        v = '0;
        v[9:0] = 10'h3FF;
        if (m == 1) begin v[7] = 1'b0; v[8] = 1'b0; end
        return v;
    endfunction

    function automatic logic [9:0] exp_native_oe(int m);
        if ((m == 1 && fdc_drv_sel == 2'd1) || (m == 2 && fdc_drv_sel <= 2'd1)) return '0;
        return '1;
    endfunction

    task automatic model_clock();
        @(posedge clk);
        if (rst) begin m_mode = 0; m_data = '0; end
        else begin
            m_mode = (mode_field == 2'b11) ? 0 : int'(mode_field);
            if (host_wr_en) m_data = host_wr_data;
        end
        #(CLK_PERIOD/4);
    endtask

    task automatic check_all();
        if (m_mode == 0) begin
            chk("R2 pin out", 32'(pp_pin_out), 32'(pp_norm_out));
            chk("R2 pin oe", 32'(pp_pin_oe), 32'(pp_norm_oe));
            chk("R2 drq", {pp_drq_out, pp_drq_oe}, {pp_drq_in, pp_drq_oe_in});
            chk("R2 irq", {pp_irq_out, pp_irq_oe}, {pp_irq_in, pp_irq_oe_in});
            chk("R2 dack", 32'(port_dack_n), 32'(pad_dack_n));
            chk("R2 regs", {host_data_rd, host_ctrl_rd, host_stat_rd},
                {port_data_rd, port_ctrl_rd, port_stat_rd});
        end else begin
            chk("R3 pin out", 32'(pp_pin_out), 32'({{(PIN_W-10){1'b0}}, fdc_sig}));
            chk("R3 pin oe", 32'(pp_pin_oe), 32'(exp_pin_oe(m_mode)));
            chk("R4 data", 32'(host_data_rd), 32'(m_data));
            chk("R5 ctrl", 32'(host_ctrl_rd), 32'h04);
            chk("R6 stat", 32'(host_stat_rd), 32'h48);
            chk("R7 dack", 32'(port_dack_n), 32'h1);
            chk("R8 drq", {pp_drq_out, pp_drq_oe}, {1'b0, ecp_mode & dma_en});
            chk("R9 irq", {pp_irq_out, pp_irq_oe}, {1'b0, ~irq_float});
        end
        chk("R10 native oe", 32'(fdc_pad_oe), 32'(exp_native_oe(m_mode)));
    endtask

    task automatic randomize_io();
        ecp_mode = 1'($urandom); dma_en = 1'($urandom); irq_float = 1'($urandom);
        fdc_drv_sel = 2'($urandom); fdc_sig = 10'($urandom);
        pp_norm_out = PIN_W'($urandom); pp_norm_oe = PIN_W'($urandom);
        pp_drq_in = 1'($urandom); pp_drq_oe_in = 1'($urandom);
        pp_irq_in = 1'($urandom); pp_irq_oe_in = 1'($urandom);
        pad_dack_n = 1'($urandom);
        port_data_rd = 8'($urandom); port_ctrl_rd = 8'($urandom); port_stat_rd = 8'($urandom);
        host_wr_en = ($urandom % 3) == 0; host_wr_data = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4721));
        repeat (3) model_clock();
        @(negedge clk);
        rst = 1'b0;
        randomize_io();
        host_wr_en = 0; pad_dack_n = 0;
        model_clock();
        chk("R11 reset mode normal", 32'(pp_pin_oe), 32'(pp_norm_oe));
        check_all();
        // R4: after reset the recalled value is 0
        @(negedge clk); mode_field = 2'b01; host_wr_en = 0;
        model_clock();
        chk("R1 one-clock follow", 32'(host_ctrl_rd), 32'h04);
        chk("R4 reset data zero", 32'(host_data_rd), 32'h0);
        // R10 single-drive mode: drive 0 keeps native pins, drive 1 releases
        @(negedge clk); fdc_drv_sel = 2'd0;
        model_clock(); chk("R10 drive0 in single mode", 32'(fdc_pad_oe), 32'h3FF);
        @(negedge clk); fdc_drv_sel = 2'd1;
        model_clock(); chk("R10 drive1 in single mode", 32'(fdc_pad_oe), 32'h0);
        // R1 reserved code acts as normal
        @(negedge clk); mode_field = 2'b11; port_ctrl_rd = 8'hA5;
        model_clock(); chk("R1 reserved normal", 32'(host_ctrl_rd), 32'hA5);
        // R4 write in normal, recall in dual mode
        @(negedge clk); mode_field = 2'b00; host_wr_en = 1; host_wr_data = 8'h3C;
        model_clock();
        @(negedge clk); mode_field = 2'b10; host_wr_en = 0;
        model_clock(); chk("R4 recall earlier write", 32'(host_data_rd), 32'h3C);
        chk("R3 dual enables ds0/mtr0", 32'(pp_pin_oe[8:7]), 32'h3);
        // R8 directed corners
        @(negedge clk); ecp_mode = 1; dma_en = 1;
        model_clock(); chk("R8 ecp+dma drives low", {pp_drq_out, pp_drq_oe}, 32'h1);
        @(negedge clk); ecp_mode = 1; dma_en = 0;
        model_clock(); chk("R8 ecp no dma floats", 32'(pp_drq_oe), 32'h0);
        // random mixed stimulus
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            randomize_io();
            if (($urandom % 8) == 0) mode_field = 2'($urandom);
            model_clock();
            check_all();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule